// File: doc/BRIEF.md
# Multi-Core External Interrupt Router

This block takes 32 level-sensitive external interrupt requests and delivers each one to one or more interrupt inputs on up to four processor cores. Every source owns an 8-bit routing entry. The lower nibble of the entry picks the target cores and the upper nibble picks the interrupt lines on those cores. An enable bit per source gates delivery. Software writes enable bits through a write-1-to-set address and a write-1-to-clear address, and reads them through a status address.

Each core gets four output lines. Line 0 to line 3 of a core feed that core's pending bits IP2 to IP5. The timer and inter-processor pending bits are generated outside this block. Source levels pass through a two-flop synchroniser. The routed result is registered before it leaves the block. A simple 32-bit register bus, with byte enables, gives access to the routing entries and to the enable state. The bus accepts a write in the cycle it is presented and returns read data combinationally in the same cycle.

Top module: `irq_router`

## Requirements
- R1: After reset every routing entry reads 0x00, every enable bit reads 0 and every core output is 0.
- R2: Routing entry n is byte (n mod 4) of the 32-bit word at byte offset 4*(n div 4), in the range 0x00 to 0x1C, so entry n sits at byte address n, little-endian. Entries are readable and writable. Writes to any other address never change an entry.
- R3: Bit 4+l of an entry (l = 0..3) routes the source to interrupt line l of the selected cores. Line l of core c is output bit coreIrq[4*c+l] and feeds that core's pending bit IP(2+l).
- R4: Bit c of an entry (c = 0..3) selects core c. The value 0x11 delivers the source to core 0, line 0, which is coreIrq[0].
- R5: A source is delivered to every combination of a selected core and a selected line. An entry with either nibble equal to zero delivers the source nowhere.
- R6: Each core output line is the logical OR of all enabled, asserted sources routed to it.
- R7: A write to offset 0x24 sets every enable bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. No other access changes an enable bit, except a write to 0x28.
- R8: A write to offset 0x28 clears every enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R9: A read of 0x20 returns the enable bits, with bit n for source n. A read of 0x2C returns the synchronised source levels. A read of 0x24, 0x28 or any unmapped offset returns 0.
- R10: A disabled source has no effect on any core output.
- R11: A source edge is presented before a clock edge e. The core outputs reflect that change from the third clock edge counted from e. A routing or enable write accepted at edge k is reflected on the outputs from edge k+1.
- R12: Byte enables qualify every write. Only the selected byte lanes of a routing word or of an enable set/clear mask take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Register access present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address; bits [1:0] ignored |
| busByteEn | input | 4 | Byte-lane enables for writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the read |
| srcIrq | input | 32 | External interrupt request levels, asynchronous |
| coreIrq | output | 16 | Core interrupt lines, bit 4*core+line |

## Verification
On every cycle, the assertions check the enable set/clear semantics and the stability of the enable bits when neither control address is written. They also check that routing entries stay fixed without a routing write, and that no output rises while no enabled source is active. The rest can only be shown by the bench's scenarios: the exact core/line decode of each nibble, fan-out to several targets, OR-merging of sources, byte-lane qualification, read-back layout and the two-to-three-cycle latency. For these, a behavioural model is compared against the outputs on every clock through directed routing sweeps and a long random phase.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  parameter int NUM_SRC   = 32;
  parameter int NUM_CORE  = 4;
  parameter int NUM_LINE  = 4;
  parameter int ENTRY_W   = 8;
  parameter int BUS_W     = 32;
  parameter int ADDR_W    = 6;

  localparam int LANES       = BUS_W / 8;
  localparam int ENT_PER_WD  = BUS_W / ENTRY_W;
  localparam int ROUTE_WORDS = NUM_SRC / ENT_PER_WD;
  localparam int WIDX_W      = (ROUTE_WORDS > 1) ? $clog2(ROUTE_WORDS) : 1;
  localparam int LINE_BASE   = ENTRY_W / 2;
  localparam int OUT_W       = NUM_CORE * NUM_LINE;

  localparam int EN_STATUS_WORD = ROUTE_WORDS;
  localparam int EN_SET_WORD    = ROUTE_WORDS + 1;
  localparam int EN_CLR_WORD    = ROUTE_WORDS + 2;
  localparam int RAW_WORD       = ROUTE_WORDS + 3;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_ROUTE = 2'd1,
    RD_EN    = 2'd2,
    RD_RAW   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic [ROUTE_WORDS-1:0] routeWe;
    logic                   enSet;
    logic                   enClr;
    logic [LANES-1:0]       byteEn;
    logic [BUS_W-1:0]       wdata;
    logic [WIDX_W-1:0]      wordIdx;
    rdSel_e                 rdSel;
  } strobe_t;
endpackage

// File: rtl/irq_router_sync.sv
module irq_router_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
(
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LANES-1:0]  busByteEn,
  input  logic [BUS_W-1:0]  busWdata,
  output strobe_t           strb
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] wordAddr;
  logic            isWr;

  assign wordAddr = busAddr[ADDR_W-1:2];
  assign isWr     = busValid && busWrite;

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_NONE;
    strb.wdata   = busWdata;
    strb.byteEn  = busByteEn;
    strb.wordIdx = wordAddr[WIDX_W-1:0];
    if (int'(wordAddr) < ROUTE_WORDS) begin
      strb.rdSel = RD_ROUTE;
      if (isWr) strb.routeWe[wordAddr[WIDX_W-1:0]] = 1'b1;
    end else if (int'(wordAddr) == EN_STATUS_WORD) begin
      strb.rdSel = RD_EN;
    end else if (int'(wordAddr) == EN_SET_WORD) begin
      strb.enSet = isWr;
    end else if (int'(wordAddr) == EN_CLR_WORD) begin
      strb.enClr = isWr;
    end else if (int'(wordAddr) == RAW_WORD) begin
      strb.rdSel = RD_RAW;
    end
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [NUM_SRC-1:0] srcSync,
  output logic [BUS_W-1:0]   rdata,
  output logic [OUT_W-1:0]   coreIrq
);
  logic [NUM_SRC-1:0][ENTRY_W-1:0] routeReg;
  logic [NUM_SRC-1:0]              enReg;
  logic [BUS_W-1:0]                enMask;
  logic [BUS_W-1:0]                maskedData;
  logic [OUT_W-1:0]                nextIrq;

  always_comb begin
    for (int b = 0; b < LANES; b++) enMask[b*8 +: 8] = {8{strb.byteEn[b]}};
  end
  assign maskedData = strb.wdata & enMask;

  // Routing entries: one byte per source, byte lanes qualified
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeReg <= '0;
    end else begin
      for (int w = 0; w < ROUTE_WORDS; w++) begin
        for (int e = 0; e < ENT_PER_WD; e++) begin
          if (strb.routeWe[w] && strb.byteEn[(e*ENTRY_W)/8])
            routeReg[w*ENT_PER_WD+e] <= strb.wdata[e*ENTRY_W +: ENTRY_W];
        end
      end
    end
  end

  // Enable bits: write-1-to-set / write-1-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= '0;
    end else if (strb.enSet) begin
      enReg <= enReg | maskedData[NUM_SRC-1:0];
    end else if (strb.enClr) begin
      enReg <= enReg & ~maskedData[NUM_SRC-1:0];
    end
  end

  // Route decode and per-line OR merge
  always_comb begin
    nextIrq = '0;
    for (int c = 0; c < NUM_CORE; c++) begin
      for (int l = 0; l < NUM_LINE; l++) begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (enReg[s] && srcSync[s] && routeReg[s][c] && routeReg[s][LINE_BASE+l])
            nextIrq[c*NUM_LINE+l] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) coreIrq <= '0;
    else       coreIrq <= nextIrq;
  end

  // Read mux
  always_comb begin
    rdata = '0;
    unique case (strb.rdSel)
      RD_ROUTE: begin
        for (int e = 0; e < ENT_PER_WD; e++)
          rdata[e*ENTRY_W +: ENTRY_W] = routeReg[int'(strb.wordIdx)*ENT_PER_WD+e];
      end
      RD_EN:   rdata[NUM_SRC-1:0] = enReg;
      RD_RAW:  rdata[NUM_SRC-1:0] = srcSync;
      default: rdata = '0;
    endcase
  end

  // Assertions
  assert_en_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.enSet |=> ((enReg & $past(maskedData[NUM_SRC-1:0])) == $past(maskedData[NUM_SRC-1:0])));

  assert_en_clr_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.enClr |=> ((enReg & $past(maskedData[NUM_SRC-1:0])) == '0));

  assert_en_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.enSet && !strb.enClr) |=> $stable(enReg));

  assert_route_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.routeWe == '0) |=> $stable(routeReg));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((enReg & srcSync) == '0) |=> (coreIrq == '0));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [5:0]  busAddr,
  input  logic [3:0]  busByteEn,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic [31:0] srcIrq,
  output logic [15:0] coreIrq
);
  strobe_t            strb;
  logic [NUM_SRC-1:0] srcSync;

  irq_router_sync #(.WIDTH(NUM_SRC)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (srcIrq),
    .syncOut (srcSync)
  );

  irq_router_ctrl ctrl_i (
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busByteEn (busByteEn),
    .busWdata  (busWdata),
    .strb      (strb)
  );

  irq_router_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .srcSync (srcSync),
    .rdata   (busRdata),
    .coreIrq (coreIrq)
  );
endmodule

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] srcIrq = '0;
  logic [15:0] coreIrq;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  irq_router dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(busRdata), .srcIrq(srcIrq), .coreIrq(coreIrq)
  );

  // Behavioural reference model
  logic [7:0]  mRoute [32];
  logic [31:0] mEn = '0, mS1 = '0, mS2 = '0;
  logic [15:0] expIrq = '0;

  initial for (int i = 0; i < 32; i++) mRoute[i] = 8'h00;

  function automatic logic [15:0] calcIrq();
    logic [15:0] r = '0;
    for (int s = 0; s < 32; s++)
      if (mEn[s] && mS2[s])
        for (int c = 0; c < 4; c++)
          for (int l = 0; l < 4; l++)
            if (mRoute[s][c] && mRoute[s][4+l]) r[c*4+l] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] expRead(input logic [5:0] a);
    int w = int'(a[5:2]);
    if (w < 8) return {mRoute[w*4+3], mRoute[w*4+2], mRoute[w*4+1], mRoute[w*4]};
    if (w == 8) return mEn;
    if (w == 11) return mS2;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] m;
    if (!rstN) begin
      for (int i = 0; i < 32; i++) mRoute[i] = 8'h00;
      mEn = '0; mS1 = '0; mS2 = '0; expIrq = '0;
    end else begin
      expIrq = calcIrq();
      mS2 = mS1;
      mS1 = srcIrq;
      if (busValid && busWrite) begin
        m = {{8{busByteEn[3]}}, {8{busByteEn[2]}}, {8{busByteEn[1]}}, {8{busByteEn[0]}}};
        if (busAddr[5:2] < 4'd8) begin
          for (int b = 0; b < 4; b++)
            if (busByteEn[b]) mRoute[int'(busAddr[5:2])*4+b] = busWdata[b*8 +: 8];
        end else if (busAddr[5:2] == 4'd9) mEn = mEn | (busWdata & m);
        else if (busAddr[5:2] == 4'd10) mEn = mEn & ~(busWdata & m);
      end
    end
    #3;
    compared++;
    if (coreIrq !== expIrq) begin
      mismatched++;
      $display("FAIL %s coreIrq got %h expected %h at %0t", curReq, coreIrq, expIrq, $time);
    end
    if (rstN && busValid && !busWrite) begin
      compared++;
      if (busRdata !== expRead(busAddr)) begin
        mismatched++;
        $display("FAIL %s read @%h got %h expected %h", curReq, busAddr, busRdata, expRead(busAddr));
      end
    end
  end

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired (got hang, expected completion)");
      finishRun();
    end
  end

  task automatic doWrite(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; busByteEn = be;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busByteEn = '0;
  endtask

  task automatic doRead(input logic [5:0] a);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic setSrc(input logic [31:0] v);
    @(negedge clk);
    srcIrq = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setEntry(input int s, input logic [7:0] v);
    doWrite(6'(s & ~3), 32'(v) << (8*(s%4)), 4'b0001 << (s%4));
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    idle(3);
    rstN = 1'b1;
    for (int a = 0; a < 48; a += 4) doRead(6'(a));

    // R4: 0x11 -> core0 line0
    curReq = "R4";
    setEntry(0, 8'h11);
    doWrite(6'h24, 32'h1, 4'hF);
    curReq = "R11";
    setSrc(32'h1); idle(5); setSrc(32'h0); idle(5);

    // R3: sweep all core/line pairs on source 5
    curReq = "R3";
    doWrite(6'h24, 32'h20, 4'hF);
    for (int c = 0; c < 4; c++)
      for (int l = 0; l < 4; l++) begin
        setEntry(5, 8'(1 << (4+l)) | 8'(1 << c));
        setSrc(32'h20); idle(4); setSrc(32'h0); idle(4);
      end

    // R5: fan-out and zero nibbles
    curReq = "R5";
    setEntry(9, 8'hFF); setEntry(10, 8'h0F); setEntry(11, 8'hF0);
    doWrite(6'h24, 32'h0E00, 4'hF);
    setSrc(32'h0400); idle(4);
    setSrc(32'h0800); idle(4);
    setSrc(32'h0200); idle(4);
    setSrc(32'h0); idle(4);

    // R6: OR merge on one line
    curReq = "R6";
    setEntry(12, 8'h24); setEntry(13, 8'h24); setEntry(14, 8'h24);
    doWrite(6'h24, 32'h7000, 4'hF);
    setSrc(32'h1000); idle(2); setSrc(32'h3000); idle(2);
    setSrc(32'h2000); idle(2); setSrc(32'h6000); idle(2);
    setSrc(32'h0); idle(4);

    // R8 / R10: clear enables and show no effect
    curReq = "R8";
    doWrite(6'h28, 32'h3000, 4'hF);
    doRead(6'h20);
    curReq = "R10";
    setSrc(32'h3000); idle(5);
    setSrc(32'h7000); idle(5);
    setSrc(32'h0); idle(4);

    // R7: zero bits in a set write leave state alone
    curReq = "R7";
    doWrite(6'h24, 32'h0, 4'hF);
    doRead(6'h20);
    doWrite(6'h24, 32'h8000_0000, 4'hF);
    doRead(6'h20);

    // R12: byte-lane qualification
    curReq = "R12";
    doWrite(6'h0C, 32'hAABBCCDD, 4'b0101);
    doRead(6'h0C);
    doWrite(6'h24, 32'hFFFF_FFFF, 4'b0001);
    doRead(6'h20);
    doWrite(6'h28, 32'hFFFF_FFFF, 4'b0010);
    doRead(6'h20);

    // R9: status and raw level reads
    curReq = "R9";
    setSrc(32'hDEADBEEF); idle(3);
    doRead(6'h2C); doRead(6'h24); doRead(6'h28); doRead(6'h30);
    setSrc(32'h0); idle(3);

    // R2: read back all routing words, write outside map
    curReq = "R2";
    doWrite(6'h30, 32'hFFFF_FFFF, 4'hF);
    for (int a = 0; a < 32; a += 4) doRead(6'(a));

    // Random mix, every clock compared
    curReq = "R6";
    for (int i = 0; i < 1500; i++) begin
      int k = int'($urandom_range(0, 9));
      if (k == 0) setEntry(int'($urandom_range(0, 31)), 8'($urandom));
      else if (k == 1) doWrite(6'h24, $urandom, 4'($urandom));
      else if (k == 2) doWrite(6'h28, $urandom, 4'($urandom));
      else if (k == 3) doRead(6'(4 * $urandom_range(0, 15)));
      else setSrc($urandom);
    end
    idle(5);
    finishRun();
  end
endmodule